// File: doc/BRIEF.md
# Pattern-Table Page Mapper with Character RAM Redirect

This block sits between the video processor's 13-bit pattern-table address (0x0000 to 0x1FFF) and the cartridge memories. It splits that 8 KB window into eight 1 KB slots. For each slot it picks a page number, then turns it into either a character ROM page or one of eight pages of a small 8 KB character RAM. It takes decoded CPU writes through one address and data strobe. Six bank registers are loaded through an index and data pair. A separate write selects horizontal or vertical nametable mirroring.

Two of the bank registers cover 2 KB each and are always even. The other four cover 1 KB each. A swap bit in the index register exchanges the two 4 KB halves of the window. Bit 6 of any page number moves that page into character RAM. The mapping outputs are combinational from the video address and the registered state. A register write therefore shows on the outputs right after the clock edge that captures it.

Top module: `gbm_chr_mapper`

## Requirements
- R1: After reset, slots 0 to 7 map to character ROM pages 0, 1, 2, 3, 4, 5, 6, 7 in that order, and mirroring is vertical (`mirror_horiz` = 0).
- R2: A data write while the index field is 0 or 1 loads 2 KB register 0 or 1 with bit 0 forced to 0. That register then feeds two consecutive slots, with page numbers value and value+1.
- R3: While `chr_rom_present` is 0, data writes with index 0 to 5 leave every slot mapping unchanged.
- R4: A data write with index 2, 3, 4 or 5 loads 1 KB register 0, 1, 2 or 3 unchanged.
- R5: When bit 6 of a slot's page number is 1, `chr_ram_sel` is 1 and `chr_page` is the page number AND 7.
- R6: When bit 6 of a slot's page number is 0, `chr_ram_sel` is 0 and `chr_page` is the page number AND (ROM_PAGES-1).
- R7: A mirroring write sets `mirror_horiz` to data bit 0 (1 means horizontal, 0 means vertical). The write has no effect while `four_screen` is 1.
- R8: Writes that decode to no register, and data writes with index 6 or 7, change no output. This includes the 0xA001 decode and every address below 0x8000.
- R9: Index-register bits 2:0 hold the index. With bit 7 = 0, slots 0 to 3 come from 2 KB registers 0 and 1 and slots 4 to 7 from 1 KB registers 0 to 3. With bit 7 = 1, the two halves are exchanged.
- R10: Writes are decoded from address bits 15:13 and bit 0 only: 0x8000 index, 0x8001 data, 0xA000 mirroring. `chr_phys_addr` equals {`chr_page`, `vid_addr`[9:0]}, and the slot is `vid_addr`[12:10].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| chr_rom_present | input | 1 | Static: cartridge carries character ROM |
| four_screen | input | 1 | Static: board supplies its own four nametables |
| vid_addr | input | 13 | Video pattern-table address |
| chr_ram_sel | output | 1 | 1 selects character RAM, 0 selects character ROM |
| chr_page | output | 8 | Physical 1 KB page number for the current slot |
| chr_phys_addr | output | 18 | Physical byte address within the selected memory |
| mirror_horiz | output | 1 | 1 horizontal, 0 vertical mirroring |

## Verification
Each register is captured on the rising edge where `cpu_wr` is high. The page outputs and the mirroring flag then follow combinationally, so every result is due in the same cycle as that edge. The bench drives a write for one cycle from a falling edge. It drops the strobe on the next falling edge, sets `vid_addr` and samples one nanosecond later. By then exactly one capturing edge has passed. For writes that must be ignored, the bench records the outputs before the write and compares them after it, in that same window.

// File: rtl/gbm_pkg.sv
package gbm_pkg;
  typedef logic [7:0] page_t;

  typedef enum logic [1:0] {
    WK_INDEX  = 2'd0,
    WK_DATA   = 2'd1,
    WK_MIRROR = 2'd2,
    WK_NONE   = 2'd3
  } wr_kind_e;

  localparam int RAM_FLAG_BIT = 6;
  localparam int RAM_PAGE_W   = 3;

  function automatic wr_kind_e decode_wr(input logic [15:0] a);
    case ({a[15:13], a[0]})
      4'b1000: decode_wr = WK_INDEX;
      4'b1001: decode_wr = WK_DATA;
      4'b1010: decode_wr = WK_MIRROR;
      default: decode_wr = WK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gbm_regs.sv
module gbm_regs
  import gbm_pkg::*;
#(
  parameter int N_WIDE   = 2,
  parameter int N_NARROW = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [15:0]              wr_addr,
  input  logic [7:0]               wr_data,
  input  logic                     rom_present,
  input  logic                     four_screen,
  output logic [N_WIDE-1:0][7:0]   wide_q,
  output logic [N_NARROW-1:0][7:0] narrow_q,
  output logic                     swap_q,
  output logic                     mirror_h_q
);
  localparam int IDX_W = 3;

  wr_kind_e           kind;
  logic [IDX_W-1:0]   idx_q;
  logic [IDX_W-1:0]   idx_d;
  logic               swap_d;
  logic               idx_en;
  logic               data_ok;
  logic               mir_en;
  logic               mir_d;
  logic [3:0]         idx_unused;

  assign idx_unused = wr_data[6:3];

  always_comb begin
    kind    = decode_wr(wr_addr);
    idx_en  = wr_en && (kind == WK_INDEX);
    idx_d   = wr_data[IDX_W-1:0];
    swap_d  = wr_data[7];
    data_ok = wr_en && (kind == WK_DATA) && rom_present;
    mir_en  = wr_en && (kind == WK_MIRROR) && !four_screen;
    mir_d   = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      swap_q <= 1'b0;
    end else if (idx_en) begin
      idx_q  <= idx_d;
      swap_q <= swap_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mirror_h_q <= 1'b0;
    else if (mir_en)  mirror_h_q <= mir_d;
  end

  for (genvar w = 0; w < N_WIDE; w++) begin : g_wide
    logic       en;
    logic [7:0] d;
    always_comb begin
      en = data_ok && (idx_q == IDX_W'(w));
      d  = {wr_data[7:1], 1'b0};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  wide_q[w] <= 8'(2 * w);
      else if (en) wide_q[w] <= d;
    end
  end

  for (genvar n = 0; n < N_NARROW; n++) begin : g_narrow
    logic en;
    always_comb en = data_ok && (idx_q == IDX_W'(N_WIDE + n));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  narrow_q[n] <= 8'(2 * N_WIDE + n);
      else if (en) narrow_q[n] <= wr_data;
    end
  end

  assert_norom_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == WK_DATA && !rom_present && idx_q < 3'd6)
      |=> ($stable(wide_q) && $stable(narrow_q)));

  assert_wide_even_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == WK_DATA && idx_q < 3'd2)
      |=> (wide_q[0][0] == 1'b0 && wide_q[1][0] == 1'b0));

  assert_fourscreen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == WK_MIRROR && four_screen) |=> $stable(mirror_h_q));

  assert_none_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == WK_NONE)
      |=> ($stable(wide_q) && $stable(narrow_q) && $stable(mirror_h_q) && $stable(swap_q)));
endmodule

// File: rtl/gbm_page_sel.sv
module gbm_page_sel
  import gbm_pkg::*;
(
  input  logic [1:0][7:0] wide_q,
  input  logic [3:0][7:0] narrow_q,
  input  logic            swap,
  input  logic [2:0]      slot,
  output page_t           page
);
  logic [2:0] eff;

  always_comb begin
    eff = slot ^ {swap, 2'b00};
    if (!eff[2]) page = {wide_q[eff[1]][7:1], eff[0]};
    else         page = narrow_q[eff[1:0]];
  end
endmodule

// File: rtl/gbm_page_xlate.sv
module gbm_page_xlate
  import gbm_pkg::*;
#(
  parameter int ROM_PAGES = 256
) (
  input  page_t page,
  output logic  ram_sel,
  output page_t phys
);
  localparam logic [7:0] ROM_MASK = 8'(ROM_PAGES - 1);
  localparam logic [7:0] RAM_MASK = 8'((1 << RAM_PAGE_W) - 1);

  always_comb begin
    ram_sel = page[RAM_FLAG_BIT];
    phys    = ram_sel ? (page & RAM_MASK) : (page & ROM_MASK);
  end
endmodule

// File: rtl/gbm_chr_mapper.sv
module gbm_chr_mapper
  import gbm_pkg::*;
#(
  parameter int ROM_PAGES = 256,
  parameter int VA_W      = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_wr,
  input  logic [15:0]          cpu_addr,
  input  logic [7:0]           cpu_data,
  input  logic                 chr_rom_present,
  input  logic                 four_screen,
  input  logic [VA_W-1:0]      vid_addr,
  output logic                 chr_ram_sel,
  output logic [7:0]           chr_page,
  output logic [VA_W+4:0]      chr_phys_addr,
  output logic                 mirror_horiz
);
  localparam int OFS_W = VA_W - 3;

  logic [1:0]      rst_sync;
  logic            rst_int_n;
  logic [1:0][7:0] wide_q;
  logic [3:0][7:0] narrow_q;
  logic            swap_q;
  page_t           page;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  gbm_regs u_regs (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .wr_en       (cpu_wr),
    .wr_addr     (cpu_addr),
    .wr_data     (cpu_data),
    .rom_present (chr_rom_present),
    .four_screen (four_screen),
    .wide_q      (wide_q),
    .narrow_q    (narrow_q),
    .swap_q      (swap_q),
    .mirror_h_q  (mirror_horiz)
  );

  gbm_page_sel u_sel (
    .wide_q   (wide_q),
    .narrow_q (narrow_q),
    .swap     (swap_q),
    .slot     (vid_addr[VA_W-1:OFS_W]),
    .page     (page)
  );

  gbm_page_xlate #(.ROM_PAGES(ROM_PAGES)) u_xlate (
    .page    (page),
    .ram_sel (chr_ram_sel),
    .phys    (chr_page)
  );

  assign chr_phys_addr = {chr_page, vid_addr[OFS_W-1:0]};

  assert_ram_range_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    chr_ram_sel |-> (chr_page[7:RAM_PAGE_W] == '0));

  assert_rom_range_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    !chr_ram_sel |-> (int'(chr_page) < ROM_PAGES));

  assert_offset_pass_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    chr_phys_addr[OFS_W-1:0] == vid_addr[OFS_W-1:0]);
endmodule

// File: tb/gbm_chr_mapper_bench.sv
module gbm_chr_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        chr_rom_present = 1'b1;
  logic        four_screen = 1'b0;
  logic [12:0] vid_addr = '0;
  logic        chr_ram_sel;
  logic [7:0]  chr_page;
  logic [17:0] chr_phys_addr;
  logic        mirror_horiz;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gbm_chr_mapper #(.ROM_PAGES(64)) u_gbm_chr_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .chr_rom_present(chr_rom_present),
    .four_screen(four_screen), .vid_addr(vid_addr),
    .chr_ram_sel(chr_ram_sel), .chr_page(chr_page),
    .chr_phys_addr(chr_phys_addr), .mirror_horiz(mirror_horiz)
  );

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_data = d;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_addr = 16'h0000;
  endtask

  task automatic chk_slot(input int slot, input bit exp_ram, input logic [7:0] exp_pg,
                          input string req);
    vid_addr = {3'(slot), 10'h2A7};
    #1;
    n_chk++;
    if (chr_ram_sel !== exp_ram || chr_page !== exp_pg ||
        chr_phys_addr !== {exp_pg, 10'h2A7}) begin
      n_bad++;
      $display("FAIL %s slot %0d: got ram=%0b page=%h addr=%h, want ram=%0b page=%h addr=%h",
               req, slot, chr_ram_sel, chr_page, chr_phys_addr, exp_ram, exp_pg,
               {exp_pg, 10'h2A7});
    end
  endtask

  task automatic chk_mir(input bit exp, input string req);
    #1;
    n_chk++;
    if (mirror_horiz !== exp) begin
      n_bad++;
      $display("FAIL %s mirror: got %0b want %0b", req, mirror_horiz, exp);
    end
  endtask

  task automatic t_reset;
    for (int s = 0; s < 8; s++) chk_slot(s, 1'b0, 8'(s), "R1");
    chk_mir(1'b0, "R1");
  endtask

  task automatic t_wide;
    wr(16'h8000, 8'h00); wr(16'h8001, 8'h13);
    chk_slot(0, 1'b0, 8'h12, "R2"); chk_slot(1, 1'b0, 8'h13, "R2");
    wr(16'h8000, 8'h01); wr(16'h9FFF, 8'h25);   // R10: alias of data address
    chk_slot(2, 1'b0, 8'h24, "R10"); chk_slot(3, 1'b0, 8'h25, "R2");
  endtask

  task automatic t_narrow;
    wr(16'h8000, 8'h02); wr(16'h8001, 8'h21);
    wr(16'h8000, 8'h03); wr(16'h8001, 8'h22);
    wr(16'h8000, 8'h04); wr(16'h8001, 8'h33);
    wr(16'h8000, 8'h05); wr(16'h8001, 8'h3F);
    chk_slot(4, 1'b0, 8'h21, "R4"); chk_slot(5, 1'b0, 8'h22, "R4");
    chk_slot(6, 1'b0, 8'h33, "R4"); chk_slot(7, 1'b0, 8'h3F, "R4");
  endtask

  task automatic t_swap;
    wr(16'h8000, 8'h80);
    chk_slot(0, 1'b0, 8'h21, "R9"); chk_slot(3, 1'b0, 8'h3F, "R9");
    chk_slot(4, 1'b0, 8'h12, "R9"); chk_slot(7, 1'b0, 8'h25, "R9");
  endtask

  task automatic t_ram;
    wr(16'h8000, 8'h82); wr(16'h8001, 8'h4D);
    wr(16'h8000, 8'h83); wr(16'h8001, 8'h7A);
    wr(16'h8000, 8'h80); wr(16'h8001, 8'h47);
    chk_slot(0, 1'b1, 8'h05, "R5"); chk_slot(1, 1'b1, 8'h02, "R5");
    chk_slot(2, 1'b0, 8'h33, "R5"); chk_slot(4, 1'b1, 8'h06, "R5");
    chk_slot(5, 1'b1, 8'h07, "R5");
  endtask

  task automatic t_mask;
    wr(16'h8000, 8'h05); wr(16'h8001, 8'h9A);
    wr(16'h8000, 8'h04); wr(16'h8001, 8'hFF);
    chk_slot(7, 1'b0, 8'h1A, "R6"); chk_slot(6, 1'b1, 8'h07, "R5");
  endtask

  task automatic t_norom;
    chr_rom_present = 1'b0;
    wr(16'h8001, 8'h11);
    chk_slot(6, 1'b1, 8'h07, "R3");
    wr(16'h8000, 8'h00); wr(16'h8001, 8'h02);
    chk_slot(0, 1'b1, 8'h06, "R3"); chk_slot(1, 1'b1, 8'h07, "R3");
    chr_rom_present = 1'b1;
  endtask

  task automatic t_mirror;
    wr(16'hA000, 8'h01); chk_mir(1'b1, "R7");
    wr(16'hBFFE, 8'h00); chk_mir(1'b0, "R10");
    four_screen = 1'b1;
    wr(16'hA000, 8'h01); chk_mir(1'b0, "R7");
    four_screen = 1'b0;
  endtask

  task automatic t_ignored;
    logic [7:0] pg [8];
    logic       rm [8];
    for (int s = 0; s < 8; s++) begin
      vid_addr = {3'(s), 10'h2A7}; #1;
      pg[s] = chr_page; rm[s] = chr_ram_sel;
    end
    wr(16'hA001, 8'hFF); wr(16'hC000, 8'h01); wr(16'hE001, 8'h00);
    wr(16'h7000, 8'h81); wr(16'h0001, 8'h55);
    wr(16'h8000, 8'h06); wr(16'h8001, 8'h7F);
    wr(16'h8000, 8'h07); wr(16'h8001, 8'h3C);
    for (int s = 0; s < 8; s++) chk_slot(s, rm[s], pg[s], "R8");
    chk_mir(1'b0, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_wide();
    t_narrow();
    t_swap();
    t_ram();
    t_mask();
    t_norom();
    t_mirror();
    t_ignored();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung run, want completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule